// File: doc/BRIEF.md
# Dynamic Bus Sizing Controller

This block is a bus master sequencer. It accepts one operand transfer request (byte, word or long word, read or write) and runs as many asynchronous bus cycles as it needs to move every operand byte to or from an external slave. The slave does not declare its width in advance. It ends each cycle with an active-low two-bit acknowledge code, and that code also tells the controller whether the port is 8 or 16 bits wide. After each cycle the controller advances the address by the number of bytes that moved. It lowers the remaining count, picks the data lanes for the next cycle, and goes on until the count is zero.

Write bytes are steered onto the 16-bit data bus so that either port width finds its byte where it expects it. Read bytes are shifted into the operand with the most significant byte first, so the finished operand comes out right-aligned. A bus error ends the cycle with or without an acknowledge, and with halt it also flags an exception. The reserved acknowledge code is treated as a bus error. During interrupt-acknowledge cycles, an autovector input ends the cycle and flags that the vector must be made internally.

Top module: `dbsz_ctrl`

## Requirements
- R1: After reset the strobe `as_no` is high and `busy_o`, `done_o`, `err_o`, `berr_halt_o` and `avec_o` are low.
- R2: While the strobe is low, acknowledge code 2'b11 (`dsack_ni[1]`, `dsack_ni[0]`) with no bus error and no autovector termination keeps the cycle open, and the address holds steady.
- R3: Code 2'b01 ends the cycle on a 16-bit port. Two bytes move when the address is even and at least two bytes remain; otherwise one byte moves, taken from lines [7:0] at an odd address and from [15:8] at an even address. A long word therefore takes two cycles.
- R4: Code 2'b10 ends the cycle on an 8-bit port. It moves one byte on lines [15:8], so a long word takes four cycles and a word takes two.
- R5: After each completed cycle the address grows by the bytes moved. `bus_siz_o` shows the remaining byte count modulo four, where 0 means four.
- R6: On writes, `bus_dout_o` carries {next byte, following byte} at an even address and {next byte, next byte} at an odd address, so the next pending byte is always on [15:8].
- R7: Read bytes are merged from most to least significant. `rdata_o` holds the operand right-aligned: a byte in [7:0], a word in [15:0].
- R8: A low `berr_ni` ends the cycle, with or without an acknowledge. It finishes the transfer with `err_o` high.
- R9: If `berr_ni` and `halt_ni` are low together, the transfer also ends with `berr_halt_o` high.
- R10: Acknowledge code 2'b00 ends the transfer as a bus error: `err_o` high, `berr_halt_o` low.
- R11: In an interrupt-acknowledge transfer (`bus_iack_o` high), a low `avec_ni` ends it with `avec_o` high. In any other transfer `avec_ni` has no effect.
- R12: `done_o` is a one-cycle pulse in the cycle after the terminating edge. The strobe goes high for at least one cycle between successive bus cycles.
- R13: `req_i` is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start a transfer (taken when idle) |
| req_rd_i | input | 1 | 1 = read, 0 = write |
| req_iack_i | input | 1 | Transfer is an interrupt acknowledge |
| req_size_i | input | 2 | 0 byte, 1 word, 2 or 3 long word |
| req_addr_i | input | AW | Start address |
| req_wdata_i | input | 32 | Write operand, right-aligned |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Transfer finished (pulse) |
| rdata_o | output | 32 | Assembled read operand, right-aligned |
| err_o | output | 1 | Last transfer ended in bus error |
| berr_halt_o | output | 1 | Last transfer ended with bus error and halt |
| avec_o | output | 1 | Last transfer ended by autovector |
| as_no | output | 1 | Bus cycle strobe, active low |
| bus_rw_o | output | 1 | 1 = read cycle |
| bus_iack_o | output | 1 | Current cycle is interrupt acknowledge |
| bus_addr_o | output | AW | Cycle address |
| bus_siz_o | output | 2 | Remaining byte count (0 = four) |
| bus_dout_o | output | 16 | Write data lanes |
| bus_din_i | input | 16 | Read data lanes |
| dsack_ni | input | 2 | Acknowledge / port size code, active low |
| berr_ni | input | 1 | Bus error, active low |
| halt_ni | input | 1 | Halt, active low |
| avec_ni | input | 1 | Autovector, active low |

## Verification
The hardest case to reach is a single transfer in which the port width changes from one cycle to the next. The lane choice and the byte count then depend on an odd address left behind by an 8-bit cycle. The bench runs a long-word read that is acknowledged first as 16-bit, then as 8-bit, then as 16-bit again at an odd address. It places junk on the unused byte lane each time, so a wrong lane or a wrong count shows up in the assembled operand. It also pulses the autovector input in an ordinary read during wait states, and raises a request in mid-transfer, to show that both are ignored at the ports.

// File: rtl/dbsz_pkg.sv
package dbsz_pkg;
  localparam int OP_BYTES = 4;
  localparam int OPW      = 8 * OP_BYTES;
  localparam int BUSW     = 16;
  localparam int CNTW     = $clog2(OP_BYTES + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_CYC, ST_GAP} st_e;

  typedef enum logic [2:0] {
    T_WAIT, T_PORT8, T_PORT16, T_BERR, T_BHALT, T_RSVD, T_AVEC
  } term_e;

  function automatic logic [CNTW-1:0] size_bytes(input logic [1:0] s);
    case (s)
      2'd0:    return CNTW'(1);
      2'd1:    return CNTW'(2);
      default: return CNTW'(OP_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/dbsz_term.sv
module dbsz_term
  import dbsz_pkg::*;
(
  input  logic [1:0] dsack_ni,
  input  logic       berr_ni,
  input  logic       halt_ni,
  input  logic       avec_ni,
  input  logic       iack_i,
  output term_e      term_o
);
  // bus error outranks everything; reserved code next; autovector only in iack
  always_comb begin
    if (!berr_ni)                 term_o = halt_ni ? T_BERR : T_BHALT;
    else if (dsack_ni == 2'b00)   term_o = T_RSVD;
    else if (iack_i && !avec_ni)  term_o = T_AVEC;
    else begin
      case (dsack_ni)
        2'b10:   term_o = T_PORT8;
        2'b01:   term_o = T_PORT16;
        default: term_o = T_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/dbsz_lane.sv
module dbsz_lane
  import dbsz_pkg::*;
(
  input  logic            addr0_i,
  input  logic [CNTW-1:0] rem_i,
  input  logic            port16_i,
  input  logic [OPW-1:0]  wsh_i,
  input  logic [OPW-1:0]  rsh_i,
  input  logic [BUSW-1:0] din_i,
  output logic [BUSW-1:0] dout_o,
  output logic [CNTW-1:0] moved_o,
  output logic [OPW-1:0]  wsh_nxt_o,
  output logic [OPW-1:0]  rsh_nxt_o
);
  logic       two_b;
  logic [7:0] rbyte;

  assign two_b   = port16_i && !addr0_i && (rem_i >= CNTW'(2));
  assign moved_o = two_b ? CNTW'(2) : CNTW'(1);

  // next pending byte always sits on the upper lane
  assign dout_o = addr0_i ? {2{wsh_i[OPW-1 -: 8]}} : wsh_i[OPW-1 -: BUSW];

  assign rbyte = (port16_i && addr0_i) ? din_i[7:0] : din_i[BUSW-1 -: 8];

  assign rsh_nxt_o = two_b ? {rsh_i[OPW-BUSW-1:0], din_i} : {rsh_i[OPW-9:0], rbyte};
  assign wsh_nxt_o = two_b ? {wsh_i[OPW-BUSW-1:0], {BUSW{1'b0}}} : {wsh_i[OPW-9:0], 8'h00};
endmodule

// File: rtl/dbsz_ctrl.sv
module dbsz_ctrl
  import dbsz_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            req_rd_i,
  input  logic            req_iack_i,
  input  logic [1:0]      req_size_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [OPW-1:0]  req_wdata_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [OPW-1:0]  rdata_o,
  output logic            err_o,
  output logic            berr_halt_o,
  output logic            avec_o,
  output logic            as_no,
  output logic            bus_rw_o,
  output logic            bus_iack_o,
  output logic [AW-1:0]   bus_addr_o,
  output logic [1:0]      bus_siz_o,
  output logic [BUSW-1:0] bus_dout_o,
  input  logic [BUSW-1:0] bus_din_i,
  input  logic [1:0]      dsack_ni,
  input  logic            berr_ni,
  input  logic            halt_ni,
  input  logic            avec_ni
);
  st_e             st_q;
  logic [AW-1:0]   addr_q;
  logic [CNTW-1:0] rem_q;
  logic            rd_q, iack_q;
  logic [OPW-1:0]  wsh_q, rsh_q;
  logic            done_q, err_q, bhalt_q, avec_q;

  term_e           term;
  logic [CNTW-1:0] moved;
  logic [OPW-1:0]  wsh_nxt, rsh_nxt, wsh_load;

  dbsz_term u_term (
    .dsack_ni (dsack_ni),
    .berr_ni  (berr_ni),
    .halt_ni  (halt_ni),
    .avec_ni  (avec_ni),
    .iack_i   (iack_q),
    .term_o   (term)
  );

  dbsz_lane u_lane (
    .addr0_i   (addr_q[0]),
    .rem_i     (rem_q),
    .port16_i  (term == T_PORT16),
    .wsh_i     (wsh_q),
    .rsh_i     (rsh_q),
    .din_i     (bus_din_i),
    .dout_o    (bus_dout_o),
    .moved_o   (moved),
    .wsh_nxt_o (wsh_nxt),
    .rsh_nxt_o (rsh_nxt)
  );

  // left-align write operand so OP0 sits at the top
  always_comb begin
    case (req_size_i)
      2'd0:    wsh_load = {req_wdata_i[7:0], {(OPW-8){1'b0}}};
      2'd1:    wsh_load = {req_wdata_i[15:0], {(OPW-16){1'b0}}};
      default: wsh_load = req_wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      rem_q   <= '0;
      rd_q    <= 1'b0;
      iack_q  <= 1'b0;
      wsh_q   <= '0;
      rsh_q   <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      bhalt_q <= 1'b0;
      avec_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_i) begin
            st_q    <= ST_CYC;
            addr_q  <= req_addr_i;
            rem_q   <= size_bytes(req_size_i);
            rd_q    <= req_rd_i;
            iack_q  <= req_iack_i;
            wsh_q   <= wsh_load;
            rsh_q   <= '0;
            err_q   <= 1'b0;
            bhalt_q <= 1'b0;
            avec_q  <= 1'b0;
          end
        end
        ST_CYC: begin
          case (term)
            T_PORT8, T_PORT16: begin
              addr_q <= addr_q + AW'(moved);
              rem_q  <= rem_q - moved;
              wsh_q  <= wsh_nxt;
              if (rd_q) rsh_q <= rsh_nxt;
              if (rem_q == moved) begin
                st_q   <= ST_IDLE;
                done_q <= 1'b1;
              end else begin
                st_q <= ST_GAP;
              end
            end
            T_BERR, T_BHALT, T_RSVD: begin
              st_q    <= ST_IDLE;
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              bhalt_q <= (term == T_BHALT);
            end
            T_AVEC: begin
              st_q   <= ST_IDLE;
              done_q <= 1'b1;
              avec_q <= 1'b1;
            end
            default: ;
          endcase
        end
        default: st_q <= ST_CYC;
      endcase
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign rdata_o     = rsh_q;
  assign err_o       = err_q;
  assign berr_halt_o = bhalt_q;
  assign avec_o      = avec_q;
  assign as_no       = (st_q != ST_CYC);
  assign bus_rw_o    = rd_q;
  assign bus_iack_o  = iack_q;
  assign bus_addr_o  = addr_q;
  assign bus_siz_o   = rem_q[1:0];
endmodule

// File: rtl/dbsz_chk.sv
module dbsz_chk #(
  parameter int AW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          as_no,
  input logic          bus_iack_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [1:0]    bus_siz_o,
  input logic [1:0]    dsack_ni,
  input logic          berr_ni,
  input logic          halt_ni,
  input logic          avec_ni,
  input logic          done_o,
  input logic          busy_o,
  input logic          err_o,
  input logic          berr_halt_o,
  input logic          avec_o
);
  logic no_avec_end;
  assign no_avec_end = avec_ni || !bus_iack_o;

  // R2
  wait_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && berr_ni && dsack_ni == 2'b11 && no_avec_end) |=> (!as_no && $stable(bus_addr_o)));

  // R3
  port16_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && berr_ni && dsack_ni == 2'b01 && no_avec_end && !bus_addr_o[0] && bus_siz_o != 2'd1)
    |=> ((bus_addr_o - $past(bus_addr_o)) == AW'(2)));

  // R4
  port8_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && berr_ni && dsack_ni == 2'b10 && no_avec_end)
    |=> ((bus_addr_o - $past(bus_addr_o)) == AW'(1)));

  // R8
  berr_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && !berr_ni) |=> (done_o && err_o && !busy_o));

  // R9
  berr_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && !berr_ni && !halt_ni) |=> berr_halt_o);

  // R10
  rsvd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && berr_ni && dsack_ni == 2'b00) |=> (done_o && err_o && !berr_halt_o));

  // R11
  avec_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_no && bus_iack_o && !avec_ni && berr_ni && dsack_ni != 2'b00) |=> (done_o && avec_o));

  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R12
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> as_no);
endmodule

bind dbsz_ctrl dbsz_chk #(.AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .as_no       (as_no),
  .bus_iack_o  (bus_iack_o),
  .bus_addr_o  (bus_addr_o),
  .bus_siz_o   (bus_siz_o),
  .dsack_ni    (dsack_ni),
  .berr_ni     (berr_ni),
  .halt_ni     (halt_ni),
  .avec_ni     (avec_ni),
  .done_o      (done_o),
  .busy_o      (busy_o),
  .err_o       (err_o),
  .berr_halt_o (berr_halt_o),
  .avec_o      (avec_o)
);

// File: tb/sim_dbsz_ctrl.sv
module sim_dbsz_ctrl;
  localparam int CLK_P = 10;
  localparam int AW    = 24;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0, req_rd_i = 1'b0, req_iack_i = 1'b0;
  logic [1:0]    req_size_i = '0;
  logic [AW-1:0] req_addr_i = '0;
  logic [31:0]   req_wdata_i = '0;
  logic          busy_o, done_o, err_o, berr_halt_o, avec_o;
  logic [31:0]   rdata_o;
  logic          as_no, bus_rw_o, bus_iack_o;
  logic [AW-1:0] bus_addr_o;
  logic [1:0]    bus_siz_o;
  logic [15:0]   bus_dout_o;
  logic [15:0]   bus_din_i = '0;
  logic [1:0]    dsack_ni = 2'b11;
  logic          berr_ni = 1'b1, halt_ni = 1'b1, avec_ni = 1'b1;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  dbsz_ctrl #(.AW(AW)) u0 (.*);

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic start(input logic rd, input logic iack, input logic [1:0] sz,
                       input logic [AW-1:0] a, input logic [31:0] wd);
    @(negedge clk_i);
    req_rd_i = rd; req_iack_i = iack; req_size_i = sz; req_addr_i = a; req_wdata_i = wd;
    req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic await_cyc(input string r, input logic [AW-1:0] a, input logic [1:0] sz);
    for (int k = 0; k < 6 && as_no; k++) @(negedge clk_i);
    chk(r, {31'd0, as_no}, 32'd0);
    chk(r, 32'(bus_addr_o), 32'(a));
    chk(r, {30'd0, bus_siz_o}, {30'd0, sz});
  endtask

  task automatic ack(input logic [1:0] ds, input logic be, input logic ha,
                     input logic av, input logic [15:0] din);
    dsack_ni = ds; berr_ni = be; halt_ni = ha; avec_ni = av; bus_din_i = din;
    @(negedge clk_i);
    dsack_ni = 2'b11; berr_ni = 1'b1; halt_ni = 1'b1; avec_ni = 1'b1; bus_din_i = 16'hEEEE;
  endtask

  task automatic expect_done(input string r, input logic [31:0] rd, input logic e,
                             input logic bh, input logic av);
    chk({r, " done"}, {31'd0, done_o}, 32'd1);
    chk({r, " rdata"}, rdata_o, rd);
    chk({r, " err"}, {31'd0, err_o}, {31'd0, e});
    chk({r, " berr_halt"}, {31'd0, berr_halt_o}, {31'd0, bh});
    chk({r, " avec"}, {31'd0, avec_o}, {31'd0, av});
  endtask

  task automatic t_reset();
    chk("R1 strobe", {31'd0, as_no}, 32'd1);
    chk("R1 busy", {31'd0, busy_o}, 32'd0);
    chk("R1 done", {31'd0, done_o}, 32'd0);
    chk("R1 flags", {29'd0, err_o, berr_halt_o, avec_o}, 32'd0);
  endtask

  task automatic t_long16_waits();
    start(1, 0, 2'd2, 24'h001000, '0);
    await_cyc("R5 long16 c1", 24'h001000, 2'd0);
    repeat (2) @(negedge clk_i);
    chk("R2 strobe held", {31'd0, as_no}, 32'd0);
    chk("R2 addr held", 32'(bus_addr_o), 32'h001000);
    chk("R2 no done", {31'd0, done_o}, 32'd0);
    ack(2'b01, 1, 1, 1, 16'h1234);
    chk("R12 gap", {31'd0, as_no}, 32'd1);
    await_cyc("R3 long16 c2", 24'h001002, 2'd2);
    ack(2'b01, 1, 1, 1, 16'h5678);
    expect_done("R3 long16", 32'h12345678, 0, 0, 0);
    @(negedge clk_i);
    chk("R12 done pulse", {31'd0, done_o}, 32'd0);
  endtask

  task automatic t_long8();
    start(1, 0, 2'd2, 24'h002000, '0);
    await_cyc("R5 long8 c1", 24'h002000, 2'd0); ack(2'b10, 1, 1, 1, 16'h11EE);
    await_cyc("R5 long8 c2", 24'h002001, 2'd3); ack(2'b10, 1, 1, 1, 16'h22EE);
    await_cyc("R5 long8 c3", 24'h002002, 2'd2); ack(2'b10, 1, 1, 1, 16'h33EE);
    await_cyc("R5 long8 c4", 24'h002003, 2'd1); ack(2'b10, 1, 1, 1, 16'h44EE);
    expect_done("R4 long8", 32'h11223344, 0, 0, 0);
  endtask

  task automatic t_word_wr8();
    start(0, 0, 2'd1, 24'h003000, 32'h0000ABCD);
    await_cyc("R4 wr8 c1", 24'h003000, 2'd2);
    chk("R6 rw", {31'd0, bus_rw_o}, 32'd0);
    chk("R6 even lanes", {16'd0, bus_dout_o}, 32'h0000ABCD);
    ack(2'b10, 1, 1, 1, 16'h0000);
    await_cyc("R4 wr8 c2", 24'h003001, 2'd1);
    chk("R6 odd lanes", {16'd0, bus_dout_o}, 32'h0000CDCD);
    ack(2'b10, 1, 1, 1, 16'h0000);
    expect_done("R4 wr8", 32'h0, 0, 0, 0);
  endtask

  task automatic t_long_wr16();
    start(0, 0, 2'd2, 24'h004000, 32'hDEADBEEF);
    await_cyc("R3 wr16 c1", 24'h004000, 2'd0);
    chk("R6 wr16 hi", {16'd0, bus_dout_o}, 32'h0000DEAD);
    ack(2'b01, 1, 1, 1, 16'h0000);
    await_cyc("R3 wr16 c2", 24'h004002, 2'd2);
    chk("R6 wr16 lo", {16'd0, bus_dout_o}, 32'h0000BEEF);
    ack(2'b01, 1, 1, 1, 16'h0000);
    expect_done("R3 wr16", 32'h0, 0, 0, 0);
  endtask

  task automatic t_bytes();
    start(1, 0, 2'd0, 24'h005001, '0);
    await_cyc("R5 byte odd", 24'h005001, 2'd1);
    ack(2'b01, 1, 1, 1, 16'h5A3C);
    expect_done("R7 byte odd16", 32'h0000003C, 0, 0, 0);
    start(1, 0, 2'd0, 24'h005002, '0);
    await_cyc("R5 byte even", 24'h005002, 2'd1);
    ack(2'b10, 1, 1, 1, 16'h77EE);
    expect_done("R7 byte even8", 32'h00000077, 0, 0, 0);
    start(1, 0, 2'd1, 24'h005004, '0);
    await_cyc("R5 word", 24'h005004, 2'd2);
    ack(2'b01, 1, 1, 1, 16'hC0DE);
    expect_done("R7 word16", 32'h0000C0DE, 0, 0, 0);
  endtask

  task automatic t_mixed();
    start(1, 0, 2'd2, 24'h006000, '0);
    await_cyc("R5 mixed c1", 24'h006000, 2'd0); ack(2'b01, 1, 1, 1, 16'hAABB);
    await_cyc("R5 mixed c2", 24'h006002, 2'd2); ack(2'b10, 1, 1, 1, 16'hCCEE);
    await_cyc("R5 mixed c3", 24'h006003, 2'd1); ack(2'b01, 1, 1, 1, 16'hEEDD);
    expect_done("R3 mixed", 32'hAABBCCDD, 0, 0, 0);
  endtask

  task automatic t_errors();
    start(1, 0, 2'd1, 24'h007000, '0);
    await_cyc("R8 berr", 24'h007000, 2'd2);
    ack(2'b11, 0, 1, 1, 16'h0);
    expect_done("R8 berr alone", 32'h0, 1, 0, 0);
    start(1, 0, 2'd2, 24'h007100, '0);
    await_cyc("R8 berr+ack", 24'h007100, 2'd0);
    ack(2'b01, 0, 1, 1, 16'h1111);
    expect_done("R8 berr with ack", 32'h0, 1, 0, 0);
    chk("R8 busy", {31'd0, busy_o}, 32'd0);
    start(1, 0, 2'd1, 24'h007200, '0);
    await_cyc("R9 halt", 24'h007200, 2'd2);
    ack(2'b11, 0, 0, 1, 16'h0);
    expect_done("R9 berr halt", 32'h0, 1, 1, 0);
    start(0, 0, 2'd1, 24'h007300, 32'h1);
    await_cyc("R10 rsvd", 24'h007300, 2'd2);
    ack(2'b00, 1, 1, 1, 16'h0);
    expect_done("R10 reserved", 32'h0, 1, 0, 0);
  endtask

  task automatic t_avec();
    start(1, 1, 2'd0, 24'hFFFFF3, '0);
    await_cyc("R11 iack", 24'hFFFFF3, 2'd1);
    chk("R11 iack flag", {31'd0, bus_iack_o}, 32'd1);
    ack(2'b11, 1, 1, 0, 16'h0);
    expect_done("R11 autovector", 32'h0, 0, 0, 1);
    start(1, 0, 2'd0, 24'h008000, '0);
    await_cyc("R11 plain", 24'h008000, 2'd1);
    ack(2'b11, 1, 1, 0, 16'h0);
    chk("R11 ignored strobe", {31'd0, as_no}, 32'd0);
    chk("R11 ignored done", {31'd0, done_o}, 32'd0);
    ack(2'b01, 1, 1, 0, 16'h99EE);
    expect_done("R11 ignored end", 32'h00000099, 0, 0, 0);
  endtask

  task automatic t_busy_req();
    start(1, 0, 2'd1, 24'h009000, '0);
    await_cyc("R13 start", 24'h009000, 2'd2);
    req_addr_i = 24'h00A000; req_size_i = 2'd0; req_i = 1'b1;
    @(negedge clk_i);
    req_i = 1'b0;
    chk("R13 addr kept", 32'(bus_addr_o), 32'h009000);
    chk("R13 siz kept", {30'd0, bus_siz_o}, 32'd2);
    ack(2'b01, 1, 1, 1, 16'h4321);
    expect_done("R13 finish", 32'h00004321, 0, 0, 0);
    repeat (2) @(negedge clk_i);
    chk("R13 no restart", {30'd0, busy_o, ~as_no}, 32'd0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    #(CLK_P * 100000);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_long16_waits();
    t_long8();
    t_word_wr8();
    t_long_wr16();
    t_bytes();
    t_mixed();
    t_errors();
    t_avec();
    t_busy_req();
    summary();
    $finish;
  end
endmodule